// File: doc/BRIEF.md
# Triggered Prescaled Timer Counter

A 16-bit timer that counts prescaled ticks up to a programmable limit. It then either wraps to zero or turns around and counts back down. It is meant to be the timebase beneath compare or capture logic elsewhere on the chip. A tick comes from either the system clock or a rising edge of an external clock pin that is resynchronised inside the block. A power-of-two prescaler thins the ticks.

One of sixteen trigger lines can be selected to control the counter. The selected trigger can hold off counting until it fires, can return the count to zero, and can restart a counter that halted itself after an overflow. Two conditions freeze the count and mask the triggers: a debug condition and a low-power doze condition, each under its own control field.

An overflow sets a sticky flag. Writing a one to the flag clears it. The flag drives an interrupt request when the overflow interrupt enable is set.

Top module: `trig_timer`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0 and the interrupt request is 0.
- R2: The prescale field d (0 to 7) makes the count advance once per 2^d source ticks. The `cfg_clkmode` encoding is: 2'b01 gives one source tick every system clock, 2'b10 gives one source tick per rising edge of `ext_clk_in`, and 2'b00 or 2'b11 holds the count unchanged.
- R3: With `cfg_updown`=0 the count runs 0, 1, …, modulo and then returns to 0. The overflow flag sets on that return to 0.
- R4: With `cfg_updown`=1 the count climbs from 0 to modulo and then descends to 0, so one period is 2·modulo ticks. The overflow flag sets on arrival at 0. A modulo of 0 keeps the count at 0 and flags an overflow every tick.
- R5: The overflow flag stays set until `ovf_clr` is pulsed. If an overflow and the clear fall in the same cycle, the flag stays set. `irq` is high exactly while the flag and `cfg_ovf_ie` are both 1.
- R6: With `cfg_start_on_trig`=1, an enabled counter stays put until the selected trigger rises. The first count step comes three clock edges after the edge that captures the trigger's rise.
- R7: With `cfg_stop_on_ovf`=1 the counter parks at 0 after an overflow. If `cfg_start_on_trig` is 0 it stays parked until it is disabled. If `cfg_start_on_trig` is 1 it waits for a new trigger rise and then counts again.
- R8: With `cfg_reload_on_trig`=1, a rise of the selected trigger sets the count to 0 two clock edges after the capturing edge, without flagging an overflow. Counting resumes on the next edge.
- R9: `cfg_trig_sel` picks bit `cfg_trig_sel` of `trig_in`. Rises on the other bits have no effect.
- R10: The counter is paused in two cases: `dbg_active` is 1 and `cfg_dbg_run` is not 2'b11, or `doze_active` and `cfg_doze_pause` are both 1. While paused the count holds and trigger rises are discarded. With `cfg_dbg_run`=2'b11 the counter keeps running in debug.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_in | input | 1 | Asynchronous external count source |
| trig_in | input | 16 | Asynchronous trigger lines |
| dbg_active | input | 1 | Chip debug condition |
| doze_active | input | 1 | Chip doze condition |
| cfg_div | input | 3 | Prescale exponent |
| cfg_clkmode | input | 2 | Tick source select |
| cfg_updown | input | 1 | 0 wrap counting, 1 up-then-down counting |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| cfg_start_on_trig | input | 1 | Wait for a trigger before counting |
| cfg_stop_on_ovf | input | 1 | Park after overflow |
| cfg_reload_on_trig | input | 1 | Trigger zeroes the count |
| cfg_trig_sel | input | 4 | Trigger line index |
| cfg_dbg_run | input | 2 | 2'b11 keeps counting during debug |
| cfg_doze_pause | input | 1 | Freeze during doze |
| modulo | input | 16 | Count limit |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
Each internal state shows up at the ports within a few edges. A prescaler phase error changes the count within 2^d cycles. A wrong direction bit shows on the next tick as a step the wrong way. A lost overflow shows as a missing flag on the edge where the count returns to 0. The run/wait/halt control state is checked by counts that move too early, too late or never after trigger rises, pauses and overflows. The sweeps land on exact cycle counts, so an off-by-one anywhere in the pipeline gives a mismatch.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DEF_CNT_W  = 16;
    localparam int DEF_TRIG_N = 16;
    localparam int DEF_DIV_W  = 3;

    typedef enum logic [1:0] {
        CM_OFF = 2'b00,
        CM_SYS = 2'b01,
        CM_EXT = 2'b10,
        CM_RSV = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_RUN,
        ST_HALT
    } tmr_state_e;

    typedef struct packed {
        logic updown;
        logic start_on_trig;
        logic stop_on_ovf;
        logic reload_on_trig;
    } tmr_ctl_t;

    function automatic logic is_counting_mode(input clk_mode_e m);
        return (m == CM_SYS) || (m == CM_EXT);
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q, stab_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= d_in;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign rise = stab_q & ~prev_q;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 3,
    localparam int PRE_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic             src,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    assign limit = PRE_W'((PRE_W + 1)'(1) << div) - PRE_W'(1);
    assign tick  = enable && src && (phase_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (enable && src) begin
            phase_q <= (phase_q == limit) ? '0 : phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    input  logic             updown,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             down_q, down_d;

    always_comb begin
        cnt_d   = cnt_q;
        down_d  = down_q && updown;
        ovf_evt = 1'b0;
        if (reload) begin
            cnt_d  = '0;
            down_d = 1'b0;
        end else if (tick) begin
            if (!updown) begin
                if (cnt_q == modulo) begin
                    cnt_d   = '0;
                    ovf_evt = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else if (!down_q) begin
                if (cnt_q >= modulo) begin
                    if (cnt_q <= ONE) begin
                        cnt_d   = '0;
                        ovf_evt = 1'b1;
                    end else begin
                        cnt_d  = cnt_q - ONE;
                        down_d = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (cnt_q <= ONE) begin
                    cnt_d   = '0;
                    ovf_evt = 1'b1;
                    down_d  = 1'b0;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            down_q <= down_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/trig_timer.sv
module trig_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int TRIG_N = DEF_TRIG_N,
    parameter int DIV_W  = DEF_DIV_W,
    localparam int SEL_W = $clog2(TRIG_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk_in,
    input  logic [TRIG_N-1:0] trig_in,
    input  logic              dbg_active,
    input  logic              doze_active,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_clkmode,
    input  logic              cfg_updown,
    input  logic              cfg_ovf_ie,
    input  logic              cfg_start_on_trig,
    input  logic              cfg_stop_on_ovf,
    input  logic              cfg_reload_on_trig,
    input  logic [SEL_W-1:0]  cfg_trig_sel,
    input  logic [1:0]        cfg_dbg_run,
    input  logic              cfg_doze_pause,
    input  logic [CNT_W-1:0]  modulo,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_flag,
    output logic              irq
);
    tmr_ctl_t    ctl;
    clk_mode_e   mode;
    tmr_state_e  state_q;
    logic [0:0]        ext_rise;
    logic [TRIG_N-1:0] trig_rise;
    logic enabled, paused, trig_ev, reload, src, run_en, tick, ovf_evt;
    logic flag_q;

    assign ctl = '{updown:         cfg_updown,
                   start_on_trig:  cfg_start_on_trig,
                   stop_on_ovf:    cfg_stop_on_ovf,
                   reload_on_trig: cfg_reload_on_trig};
    assign mode = clk_mode_e'(cfg_clkmode);

    tmr_sync #(.W(1)) u_ext_sync (
        .clk(clk), .rst(rst), .d_in(ext_clk_in), .rise(ext_rise));

    tmr_sync #(.W(TRIG_N)) u_trig_sync (
        .clk(clk), .rst(rst), .d_in(trig_in), .rise(trig_rise));

    assign enabled = is_counting_mode(mode);
    assign paused  = (dbg_active && (cfg_dbg_run != 2'b11)) ||
                     (doze_active && cfg_doze_pause);
    assign trig_ev = trig_rise[cfg_trig_sel] && !paused;
    assign reload  = trig_ev && ctl.reload_on_trig && enabled && (state_q != ST_OFF);
    assign src     = (mode == CM_SYS) || ((mode == CM_EXT) && ext_rise[0]);
    assign run_en  = (state_q == ST_RUN) && !paused;

    always_ff @(posedge clk) begin
        if (rst || !enabled) begin
            state_q <= ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:  state_q <= ctl.start_on_trig ? ST_WAIT : ST_RUN;
                ST_WAIT: if (trig_ev) state_q <= ST_RUN;
                ST_RUN:  if (ovf_evt && ctl.stop_on_ovf)
                             state_q <= ctl.start_on_trig ? ST_WAIT : ST_HALT;
                default: state_q <= ST_HALT;
            endcase
        end
    end

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst(rst),
        .clear((state_q != ST_RUN) || reload),
        .enable(run_en), .src(src), .div(cfg_div), .tick(tick));

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .reload(reload),
        .updown(ctl.updown), .modulo(modulo),
        .count(count), .ovf_evt(ovf_evt));

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (ovf_evt) flag_q <= 1'b1;
        else if (ovf_clr) flag_q <= 1'b0;
    end

    assign ovf_flag = flag_q;
    assign irq      = flag_q && cfg_ovf_ie;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic [1:0]       cfg_clkmode,
    input logic             cfg_updown,
    input logic             paused,
    input logic             ovf_evt,
    input logic             tick,
    input logic             reload,
    input tmr_state_e       state_q
);
    // R5: overflow beats a simultaneous clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);
    // R5: a clear without an overflow drops the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !ovf_evt) |=> !ovf_flag);
    // R10: a paused counter holds
    a_r10_pause_hold: assert property (@(posedge clk) disable iff (rst)
        paused |=> $stable(count));
    // R2: disabled modes hold the count
    a_r2_off_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_clkmode == 2'b00 || cfg_clkmode == 2'b11) |=> $stable(count));
    // R3: an up-mode tick steps by one or wraps to zero
    a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
        (!cfg_updown && tick && !reload) |=>
            (count == $past(count) + CNT_W'(1) || count == '0));
    // R4: up-down overflow happens on arrival at zero
    a_r4_ud_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_updown && ovf_evt) |=> count == '0);
    // R7: a halted counter holds unless reloaded
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && !reload) |=> $stable(count));
endmodule

bind trig_timer tmr_chk #(.CNT_W(CNT_W)) u_tmr_chk (
    .clk(clk), .rst(rst), .count(count), .ovf_flag(ovf_flag),
    .ovf_clr(ovf_clr), .cfg_clkmode(cfg_clkmode), .cfg_updown(cfg_updown),
    .paused(paused), .ovf_evt(ovf_evt), .tick(tick), .reload(reload),
    .state_q(state_q));

// File: tb/test_trig_timer.sv
module test_trig_timer;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ext_clk_in;
    logic [15:0] trig_in;
    logic        dbg_active, doze_active;
    logic [2:0]  cfg_div;
    logic [1:0]  cfg_clkmode;
    logic        cfg_updown, cfg_ovf_ie, cfg_start_on_trig, cfg_stop_on_ovf;
    logic        cfg_reload_on_trig, cfg_doze_pause;
    logic [3:0]  cfg_trig_sel;
    logic [1:0]  cfg_dbg_run;
    logic [15:0] modulo;
    logic        ovf_clr;
    logic [15:0] count;
    logic        ovf_flag, irq;

    int n_checks = 0;
    int n_err = 0;

    always #(PERIOD/2) clk = ~clk;

    trig_timer i_trig_timer (
        .clk(clk), .rst(rst), .ext_clk_in(ext_clk_in), .trig_in(trig_in),
        .dbg_active(dbg_active), .doze_active(doze_active),
        .cfg_div(cfg_div), .cfg_clkmode(cfg_clkmode), .cfg_updown(cfg_updown),
        .cfg_ovf_ie(cfg_ovf_ie), .cfg_start_on_trig(cfg_start_on_trig),
        .cfg_stop_on_ovf(cfg_stop_on_ovf), .cfg_reload_on_trig(cfg_reload_on_trig),
        .cfg_trig_sel(cfg_trig_sel), .cfg_dbg_run(cfg_dbg_run),
        .cfg_doze_pause(cfg_doze_pause), .modulo(modulo), .ovf_clr(ovf_clr),
        .count(count), .ovf_flag(ovf_flag), .irq(irq));

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ext_clk_in = 0; trig_in = '0; dbg_active = 0; doze_active = 0;
        cfg_div = 0; cfg_clkmode = 2'b00; cfg_updown = 0; cfg_ovf_ie = 0;
        cfg_start_on_trig = 0; cfg_stop_on_ovf = 0; cfg_reload_on_trig = 0;
        cfg_trig_sel = 0; cfg_dbg_run = 2'b00; cfg_doze_pause = 0;
        modulo = 16'd1000; ovf_clr = 0;
        step(2);
        rst = 1'b0;
    endtask

    function automatic int ud_val(input int t, input int m);
        int p;
        if (m == 0) return 0;
        p = t % (2 * m);
        return (p <= m) ? p : 2 * m - p;
    endfunction

    task automatic ext_pulses(input int k);
        for (int i = 0; i < k; i++) begin
            ext_clk_in = 1'b1; step(3);
            ext_clk_in = 1'b0; step(3);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        int mlist[4];
        int ticks, ec, eo;
        mlist = '{0, 1, 3, 6};

        // R1 reset state
        do_reset();
        check("R1 count", count, 0);
        check("R1 flag", ovf_flag, 0);
        check("R1 irq", irq, 0);

        // R2 R3 R4 sweep over direction, prescale and modulo
        for (int ud = 0; ud < 2; ud++) begin
            for (int d = 0; d < 4; d++) begin
                for (int mi = 0; mi < 4; mi++) begin
                    do_reset();
                    cfg_updown = ud[0]; cfg_div = d[2:0];
                    modulo = 16'(mlist[mi]); cfg_ovf_ie = 1;
                    cfg_clkmode = 2'b01;
                    step(41);
                    ticks = 40 >> d;
                    if (ud == 0) begin
                        ec = ticks % (mlist[mi] + 1);
                        eo = (ticks >= mlist[mi] + 1) ? 1 : 0;
                        check("R3 R2 up count", count, ec);
                        check("R3 up flag", ovf_flag, eo);
                    end else begin
                        ec = ud_val(ticks, mlist[mi]);
                        eo = (mlist[mi] == 0) ? (ticks >= 1 ? 1 : 0)
                                              : (ticks >= 2 * mlist[mi] ? 1 : 0);
                        check("R4 R2 updown count", count, ec);
                        check("R4 updown flag", ovf_flag, eo);
                    end
                    check("R5 irq follows flag", irq, eo);
                end
            end
        end

        // R2 external source, divide by 1 and 2, then disabled hold
        do_reset();
        cfg_clkmode = 2'b10;
        step(2);
        ext_pulses(7);
        step(4);
        check("R2 ext count", count, 7);
        cfg_clkmode = 2'b00;
        ext_pulses(3);
        check("R2 off hold", count, 7);
        do_reset();
        cfg_clkmode = 2'b10; cfg_div = 3'd1;
        step(2);
        ext_pulses(8);
        step(4);
        check("R2 ext div2", count, 4);

        // R6 R9 start on trigger
        do_reset();
        cfg_start_on_trig = 1; cfg_trig_sel = 4'd5; cfg_clkmode = 2'b01;
        step(10);
        check("R6 waits", count, 0);
        trig_in[4] = 1'b1; step(4); trig_in[4] = 1'b0; step(5);
        check("R9 other line ignored", count, 0);
        trig_in[5] = 1'b1;
        step(3);
        check("R6 not yet", count, 0);
        step(1);
        check("R6 first step", count, 1);
        step(5);
        check("R6 running", count, 6);
        trig_in[5] = 1'b0;

        // R7 stop on overflow, halt
        do_reset();
        cfg_stop_on_ovf = 1; modulo = 16'd3; cfg_clkmode = 2'b01;
        step(5);
        check("R7 wrapped", count, 0);
        check("R7 flag", ovf_flag, 1);
        step(10);
        check("R7 halted", count, 0);

        // R7 stop on overflow with trigger restart
        do_reset();
        cfg_stop_on_ovf = 1; cfg_start_on_trig = 1; modulo = 16'd3;
        cfg_trig_sel = 4'd2; cfg_clkmode = 2'b01;
        step(2);
        trig_in[2] = 1'b1; step(1); trig_in[2] = 1'b0;
        step(12);
        check("R7 parked", count, 0);
        check("R7 flag set", ovf_flag, 1);
        trig_in[2] = 1'b1; step(1); trig_in[2] = 1'b0;
        step(4);
        check("R7 restart", count, 2);

        // R8 reload on trigger
        do_reset();
        cfg_reload_on_trig = 1; cfg_trig_sel = 4'd7; cfg_clkmode = 2'b01;
        step(21);
        check("R8 before", count, 20);
        trig_in[7] = 1'b1;
        step(2);
        check("R8 pipeline", count, 22);
        step(1);
        check("R8 reloaded", count, 0);
        step(1);
        check("R8 resumes", count, 1);
        trig_in[7] = 1'b0;
        check("R8 no flag", ovf_flag, 0);

        // R10 pause in debug and doze
        do_reset();
        cfg_reload_on_trig = 1; cfg_trig_sel = 4'd1; cfg_clkmode = 2'b01;
        step(11);
        check("R10 start", count, 10);
        dbg_active = 1; cfg_dbg_run = 2'b00;
        step(8);
        check("R10 debug hold", count, 10);
        trig_in[1] = 1'b1; step(1); trig_in[1] = 1'b0; step(5);
        check("R10 trigger ignored", count, 10);
        dbg_active = 0;
        step(5);
        check("R10 resume", count, 15);
        dbg_active = 1; cfg_dbg_run = 2'b11;
        step(5);
        check("R10 debug run", count, 20);
        dbg_active = 0;
        doze_active = 1; cfg_doze_pause = 1;
        step(6);
        check("R10 doze hold", count, 20);
        cfg_doze_pause = 0;
        step(4);
        check("R10 doze run", count, 24);
        doze_active = 0;

        // R5 flag, enable, set priority and clear
        do_reset();
        modulo = 16'd0; cfg_clkmode = 2'b01;
        step(3);
        check("R5 flag", ovf_flag, 1);
        check("R5 irq masked", irq, 0);
        cfg_ovf_ie = 1;
        #1;
        check("R5 irq enabled", irq, 1);
        ovf_clr = 1; step(1); ovf_clr = 0;
        check("R5 set wins", ovf_flag, 1);
        do_reset();
        modulo = 16'd2; cfg_stop_on_ovf = 1; cfg_ovf_ie = 1; cfg_clkmode = 2'b01;
        step(7);
        check("R5 flag halted", ovf_flag, 1);
        ovf_clr = 1; step(1); ovf_clr = 0;
        check("R5 cleared", ovf_flag, 0);
        check("R5 irq cleared", irq, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule